// File: doc/BRIEF.md
# Width-Switchable User Register File

This block holds the programmer-visible data registers of a small CPU core: a 16-bit accumulator made of a low byte and a hidden high byte, two index registers, an emulation flag and two size flags. The size flags decide whether the accumulator and the index pair behave as 8-bit or 16-bit registers. While the emulation flag is set, both size flags are held at 8-bit. Instruction decode drives the block with flag set and clear masks, a mode-exchange request, register writes that carry a byte or word qualifier, and a command that swaps the two accumulator bytes.

The outputs show each register at its current effective width. The block also reports how many data bus cycles one accumulator access takes, and it forms a 24-bit indexed effective address from a 16-bit base, an 8-bit bank and the selected index register. The sum carries into the bank.

Top module: `widthsw_regfile`

## Requirements
- R1: After reset, emulation is on, both size flags read 1 (8-bit), the accumulator and both index registers read 0x0000, and the exchange carry output reads 0.
- R2: In the 8-bit flag masks, bit 4 selects the index size flag and bit 5 selects the accumulator size flag. A flag value of 0 means 16-bit and 1 means 8-bit. Outside emulation a set mask bit sets its flag and a clear mask bit clears it. If both are given in the same cycle, set wins.
- R3: While emulation is on, set and clear masks have no effect on either size flag.
- R4: A mode-exchange request loads the emulation flag from the carry input and puts the old emulation flag on the carry output. Entering emulation forces both size flags to 1.
- R5: The swap command exchanges the accumulator's low and high bytes in any mode. An accumulator write in the same cycle takes precedence, and the swap is then dropped.
- R6: The hidden high byte keeps its value across mode changes. When the accumulator size flag is 1 the accumulator output shows it as 0x00, and when the flag is 0 the output shows it in bits 15:8.
- R7: An accumulator write always updates the low byte from data bits 7:0. It updates the high byte from bits 15:8 only when the write is word-qualified and the accumulator size flag is 0.
- R8: While the index size flag is 1, the high bytes of both index registers read 0x00. When the flag goes from 0 to 1, those high bytes are cleared at the same clock edge and stay cleared.
- R9: With the index size flag at 0, a word-qualified index write loads all 16 bits. A byte-qualified write loads only bits 7:0 and keeps the high byte. Write enable bit 0 selects X and bit 1 selects Y.
- R10: The accumulator bus-cycle count reads 1 when the accumulator size flag is 1 and 2 when it is 0.
- R11: The effective address is {bank + carry, (base + index)[15:0]}. Here index is the effective-width value of X, or of Y when the select input is 1, and carry is the carry out of the 16-bit sum. The bank addition wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xce_req | input | 1 | Exchange the emulation flag with the carry input |
| xce_carry_i | input | 1 | Carry bit loaded into the emulation flag |
| xce_carry_o | output | 1 | Emulation flag value before the last exchange |
| flag_set | input | 8 | Status set mask (bit 5 accumulator size, bit 4 index size) |
| flag_clr | input | 8 | Status clear mask (same bit positions) |
| acc_we | input | 1 | Accumulator write enable |
| acc_word | input | 1 | Accumulator write is word-qualified |
| acc_wdata | input | 16 | Accumulator write data |
| acc_swap | input | 1 | Swap accumulator low and high bytes |
| idx_we | input | 2 | Index write enables (bit 0 X, bit 1 Y) |
| idx_word | input | 1 | Index write is word-qualified |
| idx_wdata | input | 16 | Index write data |
| ea_base | input | 16 | Base address for the indexed address |
| ea_bank | input | 8 | Bank value for the indexed address |
| ea_sel_y | input | 1 | Use Y instead of X as the index |
| emu_o | output | 1 | Emulation flag |
| msize_o | output | 1 | Accumulator size flag (1 = 8-bit) |
| xsize_o | output | 1 | Index size flag (1 = 8-bit) |
| acc_o | output | 16 | Accumulator at effective width |
| idx_x_o | output | 16 | X at effective width |
| idx_y_o | output | 16 | Y at effective width |
| acc_cycles_o | output | 2 | Data bus cycles per accumulator access |
| ea_o | output | 24 | Indexed effective address |

## Verification
The bench fills the hidden high byte through swaps while the accumulator is 8-bit, then widens the accumulator. A design that loses or zeroes that byte on a mode change shows the wrong upper half. It tries to widen the size flags during emulation, and it clears and sets the index size flag after loading full 16-bit index values. A design that only masks the high bytes on output, instead of clearing them, brings the old high bytes back when the flag is cleared again. Address cases cover a carry into the bank, a bank that wraps from 0xFF, and an 8-bit index that still carries across the page. A design that drops the carry or wraps inside 16 bits returns the wrong bank.

// File: rtl/widthsw_pkg.sv
package widthsw_pkg;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = WORD_W / 2;
  localparam int BANK_W  = 8;
  localparam int EA_W    = BANK_W + WORD_W;
  localparam int FLAG_W  = 8;
  localparam int MSZ_BIT = 5;
  localparam int XSZ_BIT = 4;
  localparam int NUM_IDX = 2;

  // Indexed address: 16-bit sum, carry into the bank, bank wraps.
  function automatic logic [EA_W-1:0] ea_calc(
    input logic [WORD_W-1:0] base,
    input logic [BANK_W-1:0] bank,
    input logic [WORD_W-1:0] idx
  );
    logic [WORD_W:0] sum;
    logic [BANK_W-1:0] bank_n;
    sum    = {1'b0, base} + {1'b0, idx};
    bank_n = bank + {{(BANK_W-1){1'b0}}, sum[WORD_W]};
    return {bank_n, sum[WORD_W-1:0]};
  endfunction

  function automatic logic [1:0] bus_cycles(input logic msize);
    return msize ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/wsw_status.sv
module wsw_status
  import widthsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xce_req,
  input  logic              xce_carry_i,
  input  logic [FLAG_W-1:0] flag_set,
  input  logic [FLAG_W-1:0] flag_clr,
  output logic              emu_q,
  output logic              msz_q,
  output logic              xsz_q,
  output logic              xsz_nxt,
  output logic              carry_q
);
  logic emu_nxt, msz_nxt;

  always_comb begin
    emu_nxt = xce_req ? xce_carry_i : emu_q;
    msz_nxt = msz_q;
    xsz_nxt = xsz_q;
    if (!emu_q) begin
      if (flag_clr[MSZ_BIT]) msz_nxt = 1'b0;
      if (flag_set[MSZ_BIT]) msz_nxt = 1'b1;
      if (flag_clr[XSZ_BIT]) xsz_nxt = 1'b0;
      if (flag_set[XSZ_BIT]) xsz_nxt = 1'b1;
    end
    if (emu_nxt) begin
      msz_nxt = 1'b1;
      xsz_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emu_q   <= 1'b1;
      msz_q   <= 1'b1;
      xsz_q   <= 1'b1;
      carry_q <= 1'b0;
    end else begin
      emu_q <= emu_nxt;
      msz_q <= msz_nxt;
      xsz_q <= xsz_nxt;
      if (xce_req) carry_q <= emu_q;
    end
  end

  logic unused_mask_bits;
  assign unused_mask_bits = ^{flag_set, flag_clr};

  AST_EMU_LOCKS_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    emu_q |-> (msz_q && xsz_q)); // R3
  AST_XCE_RETURNS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    xce_req |=> (carry_q == $past(emu_q) && emu_q == $past(xce_carry_i))); // R4
endmodule

// File: rtl/wsw_accum.sv
module wsw_accum
  import widthsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msz_q,
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              swap,
  output logic [WORD_W-1:0] acc_o,
  output logic [1:0]        cycles_o
);
  logic [BYTE_W-1:0] lo_q, hi_q, lo_nxt, hi_nxt;
  logic              wide_write;

  assign wide_write = wr_en && wr_word && !msz_q;

  always_comb begin
    lo_nxt = lo_q;
    hi_nxt = hi_q;
    if (wr_en) begin
      lo_nxt = wr_data[BYTE_W-1:0];
      if (wide_write) hi_nxt = wr_data[WORD_W-1:BYTE_W];
    end else if (swap) begin
      lo_nxt = hi_q;
      hi_nxt = lo_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_nxt;
      hi_q <= hi_nxt;
    end
  end

  assign acc_o    = msz_q ? {{BYTE_W{1'b0}}, lo_q} : {hi_q, lo_q};
  assign cycles_o = bus_cycles(msz_q);

  AST_SWAP_EXCHANGES: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && !wr_en) |=> (lo_q == $past(hi_q) && hi_q == $past(lo_q))); // R5
  AST_NARROW_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(wr_word && !msz_q)) |=> $stable(hi_q)); // R7
  AST_HI_SURVIVES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !swap) |=> $stable(hi_q)); // R6
endmodule

// File: rtl/wsw_index.sv
module wsw_index
  import widthsw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xsz_q,
  input  logic               xsz_nxt,
  input  logic [NUM_IDX-1:0] wr_en,
  input  logic               wr_word,
  input  logic [WORD_W-1:0]  wr_data,
  output logic [WORD_W-1:0]  idx_o [NUM_IDX]
);
  for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
    logic [BYTE_W-1:0] lo_q, hi_q;
    logic              hi_load;

    assign hi_load = wr_en[g] && wr_word && !xsz_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (wr_en[g]) lo_q <= wr_data[BYTE_W-1:0];
        if (xsz_nxt)      hi_q <= '0;
        else if (hi_load) hi_q <= wr_data[WORD_W-1:BYTE_W];
      end
    end

    assign idx_o[g] = {hi_q, lo_q};

    AST_IDX_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      xsz_q |-> (hi_q == '0)); // R8
  end
endmodule

// File: rtl/wsw_ea.sv
module wsw_ea
  import widthsw_pkg::*;
(
  input  logic [WORD_W-1:0] base,
  input  logic [BANK_W-1:0] bank,
  input  logic              sel_y,
  input  logic [WORD_W-1:0] x_val,
  input  logic [WORD_W-1:0] y_val,
  output logic [EA_W-1:0]   ea_o
);
  logic [WORD_W-1:0] idx_sel;
  assign idx_sel = sel_y ? y_val : x_val;
  assign ea_o    = ea_calc(base, bank, idx_sel);
endmodule

// File: rtl/widthsw_regfile.sv
module widthsw_regfile
  import widthsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xce_req,
  input  logic              xce_carry_i,
  output logic              xce_carry_o,
  input  logic [FLAG_W-1:0] flag_set,
  input  logic [FLAG_W-1:0] flag_clr,
  input  logic              acc_we,
  input  logic              acc_word,
  input  logic [WORD_W-1:0] acc_wdata,
  input  logic              acc_swap,
  input  logic [1:0]        idx_we,
  input  logic              idx_word,
  input  logic [WORD_W-1:0] idx_wdata,
  input  logic [WORD_W-1:0] ea_base,
  input  logic [BANK_W-1:0] ea_bank,
  input  logic              ea_sel_y,
  output logic              emu_o,
  output logic              msize_o,
  output logic              xsize_o,
  output logic [WORD_W-1:0] acc_o,
  output logic [WORD_W-1:0] idx_x_o,
  output logic [WORD_W-1:0] idx_y_o,
  output logic [1:0]        acc_cycles_o,
  output logic [EA_W-1:0]   ea_o
);
  logic              xsz_nxt;
  logic [WORD_W-1:0] idx_vals [NUM_IDX];

  wsw_status u_status (
    .clk(clk), .rst_n(rst_n), .xce_req(xce_req), .xce_carry_i(xce_carry_i),
    .flag_set(flag_set), .flag_clr(flag_clr), .emu_q(emu_o), .msz_q(msize_o),
    .xsz_q(xsize_o), .xsz_nxt(xsz_nxt), .carry_q(xce_carry_o)
  );

  wsw_accum u_accum (
    .clk(clk), .rst_n(rst_n), .msz_q(msize_o), .wr_en(acc_we),
    .wr_word(acc_word), .wr_data(acc_wdata), .swap(acc_swap),
    .acc_o(acc_o), .cycles_o(acc_cycles_o)
  );

  wsw_index u_index (
    .clk(clk), .rst_n(rst_n), .xsz_q(xsize_o), .xsz_nxt(xsz_nxt),
    .wr_en(idx_we), .wr_word(idx_word), .wr_data(idx_wdata), .idx_o(idx_vals)
  );

  assign idx_x_o = idx_vals[0];
  assign idx_y_o = idx_vals[1];

  wsw_ea u_ea (
    .base(ea_base), .bank(ea_bank), .sel_y(ea_sel_y),
    .x_val(idx_x_o), .y_val(idx_y_o), .ea_o(ea_o)
  );

  AST_CYCLES_TRACK_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msize_o) |-> (acc_cycles_o == 2'd2)); // R10
endmodule

// File: tb/widthsw_regfile_bench.sv
`timescale 1ns/1ps
module widthsw_regfile_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic xce_req, xce_carry_i, xce_carry_o;
  logic [7:0] flag_set, flag_clr;
  logic acc_we, acc_word, acc_swap, idx_word, ea_sel_y;
  logic [15:0] acc_wdata, idx_wdata, ea_base;
  logic [1:0] idx_we;
  logic [7:0] ea_bank;
  logic emu_o, msize_o, xsize_o;
  logic [15:0] acc_o, idx_x_o, idx_y_o;
  logic [1:0] acc_cycles_o;
  logic [23:0] ea_o;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  widthsw_regfile u_widthsw_regfile (.*);

  // {sel_y, base, bank, index, expected address}
  localparam logic [64:0] VEC [6] = '{
    {1'b0, 16'h1000, 8'h00, 16'h0234, 24'h001234},
    {1'b0, 16'hFFFF, 8'h01, 16'h0001, 24'h020000},
    {1'b0, 16'h8000, 8'h7F, 16'h8000, 24'h800000},
    {1'b1, 16'h0000, 8'h3C, 16'h0000, 24'h3C0000},
    {1'b0, 16'hFFFF, 8'hFF, 16'hFFFF, 24'h00FFFE},
    {1'b1, 16'h1234, 8'h05, 16'hEDCB, 24'h05FFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    xce_req = 0; xce_carry_i = 0; flag_set = 0; flag_clr = 0;
    acc_we = 0; acc_word = 0; acc_wdata = 0; acc_swap = 0;
    idx_we = 0; idx_word = 0; idx_wdata = 0;
  endtask

  task automatic tick();
    @(posedge clk); #2; idle();
  endtask

  task automatic acc_wr(input logic word, input logic [15:0] d, input logic sw);
    acc_we = 1; acc_word = word; acc_wdata = d; acc_swap = sw; tick();
  endtask

  task automatic idx_wr(input logic [1:0] we, input logic word, input logic [15:0] d);
    idx_we = we; idx_word = word; idx_wdata = d; tick();
  endtask

  task automatic xce(input logic c);
    xce_req = 1; xce_carry_i = c; tick();
  endtask

  task automatic flags(input logic [7:0] s, input logic [7:0] c);
    flag_set = s; flag_clr = c; tick();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(); ea_base = 0; ea_bank = 0; ea_sel_y = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    check("R1 emu", emu_o, 1); check("R1 msize", msize_o, 1); check("R1 xsize", xsize_o, 1);
    check("R1 acc", acc_o, 0); check("R1 X", idx_x_o, 0); check("R1 Y", idx_y_o, 0);
    check("R1 carry", xce_carry_o, 0);
    // R3 masks ignored in emulation
    flags(8'h00, 8'h30);
    check("R3 msize", msize_o, 1); check("R3 xsize", xsize_o, 1);
    // R7/R5 fill hidden byte through swaps
    acc_wr(1, 16'h1234, 0); check("R7 word write while 8-bit", acc_o, 16'h0034);
    acc_swap = 1; tick(); check("R5 swap 8-bit", acc_o, 16'h0000);
    acc_wr(0, 16'h0056, 0); acc_swap = 1; tick(); check("R5 swap back", acc_o, 16'h0034);
    // R8 index high byte held while 8-bit
    idx_wr(2'b01, 1, 16'hABCD); check("R8 X 8-bit", idx_x_o, 16'h00CD);
    // R4 enter native
    xce(0); check("R4 emu", emu_o, 0); check("R4 carry", xce_carry_o, 1);
    check("R4 msize kept", msize_o, 1);
    // R6/R10 widen accumulator
    flags(8'h00, 8'h20);
    check("R6 hidden byte", acc_o, 16'h5634); check("R10 two cycles", acc_cycles_o, 2);
    check("R2 x untouched", xsize_o, 1);
    flags(8'h10, 8'h10); check("R2 set wins", xsize_o, 1);
    flags(8'h00, 8'h10); check("R2 clear x", xsize_o, 0);
    // R9 index writes
    idx_wr(2'b01, 1, 16'hBEEF); check("R9 X word", idx_x_o, 16'hBEEF);
    idx_wr(2'b10, 0, 16'h1277); check("R9 Y byte", idx_y_o, 16'h0077);
    idx_wr(2'b01, 0, 16'h0011); check("R9 X byte", idx_x_o, 16'hBE11);
    // R7/R5 accumulator in 16-bit mode
    acc_wr(1, 16'hCAFE, 0); check("R7 word", acc_o, 16'hCAFE);
    acc_wr(0, 16'h0099, 0); check("R7 byte", acc_o, 16'hCA99);
    acc_swap = 1; tick(); check("R5 swap 16-bit", acc_o, 16'h99CA);
    acc_wr(1, 16'h1111, 1); check("R5 write beats swap", acc_o, 16'h1111);
    // R11 table of address cases
    for (int i = 0; i < 6; i++) begin
      logic [64:0] v;
      v = VEC[i];
      idx_wr(v[64] ? 2'b10 : 2'b01, 1, v[39:24]);
      ea_sel_y = v[64]; ea_base = v[63:48]; ea_bank = v[47:40];
      #1 check($sformatf("R11 vec %0d", i), ea_o, v[23:0]);
    end
    // R8 x set clears high bytes, clearing x again does not restore them
    flags(8'h10, 8'h00);
    check("R8 X cleared", idx_x_o, 16'h00FF); check("R8 Y cleared", idx_y_o, 16'h00CB);
    flags(8'h00, 8'h10);
    check("R8 X stays", idx_x_o, 16'h00FF); check("R8 Y stays", idx_y_o, 16'h00CB);
    // R10 back to 8-bit accumulator
    flags(8'h20, 8'h00);
    check("R6 narrow view", acc_o, 16'h0011); check("R10 one cycle", acc_cycles_o, 1);
    // R4 re-enter emulation from fully wide state
    idx_wr(2'b01, 1, 16'h4321);
    flags(8'h00, 8'h30);
    xce(1);
    check("R4 emu on", emu_o, 1); check("R4 m forced", msize_o, 1);
    check("R4 x forced", xsize_o, 1); check("R4 old e", xce_carry_o, 0);
    check("R8 X on emu entry", idx_x_o, 16'h0021);
    flags(8'h00, 8'h30); check("R3 locked again", msize_o, 1);
    // R11 8-bit index still carries into bank
    ea_sel_y = 0; ea_base = 16'hFFF0; ea_bank = 8'h12;
    #1 check("R11 8-bit index carry", ea_o, 24'h130011);
    // R6 hidden byte kept across emulation round trip
    xce(0); check("R4 carry after exit", xce_carry_o, 1);
    flags(8'h00, 8'h20); check("R6 hidden byte kept", acc_o, 16'h1111);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule